// File: doc/BRIEF.md
# VLAN Table Command Engine

This block holds a small VLAN membership table and runs commands on it that a host issues through a register port. Each table slot holds a 13-bit VLAN identifier, a valid flag, an 8-bit filtering database number and a 2-bit membership code for each port. The host fills a VID register and three port-data registers. It then writes the command register with its start bit set and polls that bit until it drops.

Three commands exist: load-or-purge, get-next and flush. Load-or-purge writes or overwrites the slot for the VID held in the VID register when the register's valid bit is set. When the valid bit is clear, it removes that slot. Get-next finds the lowest valid VID above the value in the VID register and writes it back there, together with its database number and member codes. Repeating get-next without touching the VID register therefore walks the table in ascending VID order. Flush empties the table.

Every command scans all table slots, one slot per cycle, and commits its result in one final cycle. While a command is busy, the block ignores host writes to every register.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, the command register reads 0 (not busy, full flag clear) and the VID register reads 0. A get-next started from VID 0x1FFF then reports no entry.
- R2: Writing the command register (address 0) with bit 15 set starts the command in bits 14:12 (1 = flush, 3 = load/purge, 4 = get-next). Bit 15 then reads 1 for exactly DEPTH+1 cycles.
- R3: The VID register (address 1) holds VID[11:0] in bits 11:0, VID bit 12 in bit 13 and the valid flag in bit 12. Bits 15:14 read 0.
- R4: Load with the valid flag set stores the VID, the database number and the member codes. Loading a VID that is already present overwrites that entry.
- R5: Load with the valid flag clear removes the entry with that VID. If no such entry exists, the table is unchanged.
- R6: Get-next writes the lowest valid VID strictly above the VID register value into the VID register with the valid flag set. It also loads that entry's database number into the command register and its member codes into the data registers. Repeated get-next calls return entries in ascending order.
- R7: When no higher valid entry exists, get-next clears the valid flag and leaves the VID bits unchanged.
- R8: A get-next started from VID 0x1FFF returns the lowest valid VID in the table.
- R9: Port p has its member code in data register p/4 (addresses 2 to 4), bits (p%4)*4+1:(p%4)*4. The two bits above that field (port state) are not stored, so they read 0 after a get-next.
- R10: The database number is split across the command register: bits 3:0 hold db[3:0] and bits 11:8 hold db[7:4]. Load uses this split and get-next returns the number in the same split.
- R11: Flush invalidates every entry and clears the full flag.
- R12: A load of a new VID into a full table leaves the table unchanged and sets a sticky full flag (command register bit 4). An overwrite of a VID that is present still works on a full table.
- R13: A host write to any register while busy is ignored. This includes a write in the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 command, 1 VID, 2 to 4 data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |

## Verification
Two things can land in the same cycle: the get-next result being written back into the VID and data registers, and a host write to those same registers. The bench starts a get-next and writes a data register in the first busy cycle. It then times a VID register write so that it arrives on exactly the commit edge. The test passes only if both host writes are lost and the registers hold the model's get-next result. A second collision check covers a load on a full table, where the full-flag set and the write to a slot must exclude each other.

// File: rtl/vte_pkg.sv
package vte_pkg;
  localparam int VID_W     = 13;
  localparam int DB_W      = 8;
  localparam int MAX_PORTS = 12;
  localparam int MEM_W     = 2 * MAX_PORTS;
  localparam int REG_W     = 16;
  localparam logic [VID_W-1:0] VID_ALL = '1;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_FLUSH = 3'd1,
    OPC_LOAD  = 3'd3,
    OPC_NEXT  = 3'd4
  } opc_e;

  typedef struct packed {
    logic             valid;
    logic [VID_W-1:0] vid;
    logic [DB_W-1:0]  db;
    logic [MEM_W-1:0] mem;
  } ent_t;

  function automatic logic [DB_W-1:0] db_from_cmd(input logic [REG_W-1:0] w);
    return {w[11:8], w[3:0]};
  endfunction

  function automatic logic [VID_W-1:0] vid_from_reg(input logic [REG_W-1:0] w);
    return {w[13], w[11:0]};
  endfunction

  function automatic logic [REG_W-1:0] vid_to_reg(input logic [VID_W-1:0] v,
                                                  input logic ok);
    return {2'b00, v[12], ok, v[11:0]};
  endfunction

  // member code of port p sits in word p/4 at bit (p%4)*4
  function automatic logic [MEM_W-1:0] mem_from_data(input logic [3*REG_W-1:0] d);
    logic [MEM_W-1:0] m;
    m = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      m[2*p +: 2] = d[REG_W*(p/4) + (p%4)*4 +: 2];
    return m;
  endfunction

  function automatic logic [3*REG_W-1:0] data_from_mem(input logic [MEM_W-1:0] m);
    logic [3*REG_W-1:0] d;
    d = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      d[REG_W*(p/4) + (p%4)*4 +: 2] = m[2*p +: 2];
    return d;
  endfunction

  // start value VID_ALL stands below every VID
  function automatic logic vid_above(input logic [VID_W-1:0] cand,
                                     input logic [VID_W-1:0] key);
    return (key == VID_ALL) || (cand > key);
  endfunction
endpackage

// File: rtl/vte_table.sv
module vte_table
  import vte_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output ent_t                     rd_ent,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  ent_t                     wr_ent,
  input  logic                     clr_all,
  output logic [DEPTH-1:0]         valid_vec
);
  ent_t slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[i] <= '0;
      else if (clr_all)
        slots[i].valid <= 1'b0;
      else if (wr_en && (wr_idx == i[$clog2(DEPTH)-1:0]))
        slots[i] <= wr_ent;
    end
    assign valid_vec[i] = slots[i].valid;
  end

  assign rd_ent = slots[rd_idx];

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_vec == '0));
  p_clear_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_all && wr_en));
endmodule

// File: rtl/vte_scan.sv
module vte_scan
  import vte_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [2:0]               opc_i,
  input  logic [VID_W-1:0]         key_vid_i,
  input  logic                     key_valid_i,
  input  ent_t                     ent_i,
  output logic [$clog2(DEPTH)-1:0] rd_idx_o,
  output logic                     busy_o,
  output logic                     commit_o,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_idx_o,
  output logic                     wr_valid_o,
  output logic                     clr_all_o,
  output logic                     full_set_o,
  output logic                     hit_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             busy_q, last_q;
  logic [IDX_W-1:0] idx_q;
  logic             match_f, free_f, best_f;
  logic [IDX_W-1:0] match_i, free_i, best_i;
  logic [VID_W-1:0] best_v;

  // per-slot events of the scan step
  logic step, slot_match, slot_free, slot_better;
  assign step        = busy_q && !last_q;
  assign slot_match  = ent_i.valid && (ent_i.vid == key_vid_i);
  assign slot_free   = !ent_i.valid;
  assign slot_better = ent_i.valid && vid_above(ent_i.vid, key_vid_i) &&
                       (!best_f || (ent_i.vid < best_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      idx_q   <= '0;
      match_f <= 1'b0;
      free_f  <= 1'b0;
      best_f  <= 1'b0;
      match_i <= '0;
      free_i  <= '0;
      best_i  <= '0;
      best_v  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        last_q  <= 1'b0;
        idx_q   <= '0;
        match_f <= 1'b0;
        free_f  <= 1'b0;
        best_f  <= 1'b0;
      end
    end else if (step) begin
      if (slot_match && !match_f) begin
        match_f <= 1'b1;
        match_i <= idx_q;
      end
      if (slot_free && !free_f) begin
        free_f <= 1'b1;
        free_i <= idx_q;
      end
      if (slot_better) begin
        best_f <= 1'b1;
        best_i <= idx_q;
        best_v <= ent_i.vid;
      end
      if (idx_q == LAST_IDX) begin
        last_q <= 1'b1;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && last_q;
  assign rd_idx_o = last_q ? best_i : idx_q;

  always_comb begin
    wr_en_o    = 1'b0;
    wr_idx_o   = '0;
    wr_valid_o = 1'b0;
    clr_all_o  = 1'b0;
    full_set_o = 1'b0;
    hit_o      = 1'b0;
    if (commit_o) begin
      case (opc_i)
        OPC_LOAD: begin
          if (match_f) begin
            wr_en_o    = 1'b1;
            wr_idx_o   = match_i;
            wr_valid_o = key_valid_i;
          end else if (key_valid_i && free_f) begin
            wr_en_o    = 1'b1;
            wr_idx_o   = free_i;
            wr_valid_o = 1'b1;
          end else if (key_valid_i) begin
            full_set_o = 1'b1;
          end
        end
        OPC_FLUSH: clr_all_o = 1'b1;
        OPC_NEXT:  hit_o     = best_f;
        default: ;
      endcase
    end
  end

  p_start_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !commit_o && rd_idx_o == '0));
  p_full_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, full_set_o, clr_all_o, hit_o}));
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vte_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_PORTS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 2) + 1;
  localparam logic [MEM_W:0] MASK_WIDE = (MEM_W+1)'(1) << (2 * NUM_PORTS);
  localparam logic [MEM_W-1:0] PORT_MASK = MEM_W'(MASK_WIDE - 1'b1);

  localparam logic [2:0] A_CMD = 3'd0;
  localparam logic [2:0] A_VID = 3'd1;
  localparam logic [2:0] A_D0  = 3'd2;
  localparam logic [2:0] A_D1  = 3'd3;
  localparam logic [2:0] A_D2  = 3'd4;

  logic [2:0]         opc_q;
  logic [DB_W-1:0]    db_q;
  logic               full_q;
  logic [VID_W-1:0]   vid_q;
  logic               vok_q;
  logic [3*REG_W-1:0] data_q;

  logic             busy, commit, wr_en, wr_valid, clr_all, full_set, hit;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  ent_t             rd_ent, wr_ent;
  logic [DEPTH-1:0] valid_vec;

  // host-side events
  logic host_wr, start;
  assign host_wr = reg_wr && !busy;
  assign start   = host_wr && (reg_addr == A_CMD) && reg_wdata[15];

  assign wr_ent = '{valid: wr_valid, vid: vid_q, db: db_q,
                    mem: mem_from_data(data_q) & PORT_MASK};

  vte_table #(.DEPTH(DEPTH)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_ent    (rd_ent),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_ent    (wr_ent),
    .clr_all   (clr_all),
    .valid_vec (valid_vec)
  );

  vte_scan #(.DEPTH(DEPTH)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .opc_i       (opc_q),
    .key_vid_i   (vid_q),
    .key_valid_i (vok_q),
    .ent_i       (rd_ent),
    .rd_idx_o    (rd_idx),
    .busy_o      (busy),
    .commit_o    (commit),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_valid_o  (wr_valid),
    .clr_all_o   (clr_all),
    .full_set_o  (full_set),
    .hit_o       (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q  <= '0;
      db_q   <= '0;
      full_q <= 1'b0;
      vid_q  <= '0;
      vok_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (host_wr) begin
        case (reg_addr)
          A_CMD: begin
            opc_q <= reg_wdata[14:12];
            db_q  <= db_from_cmd(reg_wdata);
          end
          A_VID: begin
            vid_q <= vid_from_reg(reg_wdata);
            vok_q <= reg_wdata[12];
          end
          A_D0: data_q[0*REG_W +: REG_W] <= reg_wdata;
          A_D1: data_q[1*REG_W +: REG_W] <= reg_wdata;
          A_D2: data_q[2*REG_W +: REG_W] <= reg_wdata;
          default: ;
        endcase
      end
      if (hit) begin
        vid_q  <= rd_ent.vid;
        vok_q  <= 1'b1;
        db_q   <= rd_ent.db;
        data_q <= data_from_mem(rd_ent.mem);
      end else if (commit && (opc_q == OPC_NEXT)) begin
        vok_q <= 1'b0;
      end
      if (full_set)
        full_q <= 1'b1;
      else if (clr_all)
        full_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {busy, opc_q, db_q[7:4], 3'b000, full_q, db_q[3:0]};
      A_VID:   reg_rdata = vid_to_reg(vid_q, vok_q);
      A_D0:    reg_rdata = data_q[0*REG_W +: REG_W];
      A_D1:    reg_rdata = data_q[1*REG_W +: REG_W];
      A_D2:    reg_rdata = data_q[2*REG_W +: REG_W];
      default: reg_rdata = '0;
    endcase
  end

  // busy length counter for the checker
  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (start) busy_cnt <= '0;
    else if (busy)  busy_cnt <= busy_cnt + 1'b1;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(DEPTH + 1)));
  p_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> ($stable(vid_q) && $stable(vok_q) && $stable(data_q) &&
                           $stable(db_q) && $stable(opc_q)));
  p_full_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr_all) |=> full_q);
  p_next_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (vok_q && ((vid_q > $past(vid_q)) || ($past(vid_q) == VID_ALL))));
  p_next_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (opc_q == OPC_NEXT) && !hit) |=> (!vok_q && $stable(vid_q)));
  p_no_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    full_set |-> (valid_vec == '1));
endmodule

// File: tb/test_vlan_cmd_engine.sv
module test_vlan_cmd_engine;
  localparam int DEPTH = 8;
  localparam logic [47:0] MEMBITS = 48'h3333_3333_3333;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;

  int ncmp = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  vlan_cmd_engine #(.DEPTH(DEPTH), .NUM_PORTS(12)) i_vlan_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // bench model
  logic        m_ok  [DEPTH];
  logic [12:0] m_vid [DEPTH];
  logic [7:0]  m_db  [DEPTH];
  logic [47:0] m_dat [DEPTH];
  logic        m_full = 1'b0;
  logic [12:0] cur_vid = 13'h0;

  // vectors: vid, db, data word 0; words 1 and 2 derived
  localparam logic [36:0] VEC [6] = '{
    {13'h0123, 8'h5A, 16'h1221},
    {13'h1005, 8'hC3, 16'h3003},
    {13'h0040, 8'h01, 16'hFFFF},
    {13'h0FFF, 8'hF0, 16'h2112},
    {13'h0002, 8'h80, 16'h0000},
    {13'h1800, 8'h7E, 16'h1331}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] cmd_word(input logic [2:0] opc, input logic [7:0] db);
    return {1'b1, opc, db[7:4], 4'b0000, db[3:0]};
  endfunction

  task automatic wait_idle(output int cyc);
    logic [15:0] r;
    cyc = 0;
    rd(3'd0, r);
    while (r[15]) begin
      cyc++;
      @(posedge clk);
      rd(3'd0, r);
    end
  endtask

  task automatic run_cmd(input logic [15:0] w);
    int cyc;
    wr(3'd0, w);
    wait_idle(cyc);
    chk("R2 busy length", 16'(cyc), 16'(DEPTH + 1));
  endtask

  task automatic model_load(input logic [12:0] v, input logic ok,
                            input logic [7:0] db, input logic [47:0] d);
    int hit = -1;
    int fr = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_ok[i] && m_vid[i] == v && hit < 0) hit = i;
      if (!m_ok[i] && fr < 0) fr = i;
    end
    if (hit >= 0) begin
      m_ok[hit] = ok; m_db[hit] = db; m_dat[hit] = d & MEMBITS;
    end else if (ok && fr >= 0) begin
      m_ok[fr] = 1'b1; m_vid[fr] = v; m_db[fr] = db; m_dat[fr] = d & MEMBITS;
    end else if (ok) begin
      m_full = 1'b1;
    end
  endtask

  task automatic load(input logic [12:0] v, input logic ok, input logic [7:0] db,
                      input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2);
    wr(3'd1, {2'b00, v[12], ok, v[11:0]});
    wr(3'd2, d0);
    wr(3'd3, d1);
    wr(3'd4, d2);
    run_cmd(cmd_word(3'd3, db));
    model_load(v, ok, db, {d2, d1, d0});
  endtask

  task automatic set_key(input logic [12:0] v);
    wr(3'd1, {2'b00, v[12], 1'b0, v[11:0]});
    cur_vid = v;
  endtask

  // compare registers with the model's next entry; returns 1 on a hit
  task automatic check_next(input string req, output logic found);
    int bi = -1;
    logic [15:0] r;
    for (int i = 0; i < DEPTH; i++)
      if (m_ok[i] && (cur_vid == 13'h1FFF || m_vid[i] > cur_vid) &&
          (bi < 0 || m_vid[i] < m_vid[bi])) bi = i;
    rd(3'd1, r);
    if (bi < 0) begin
      found = 1'b0;
      chk({req, " R7 miss vid"}, r, {2'b00, cur_vid[12], 1'b0, cur_vid[11:0]});
    end else begin
      found = 1'b1;
      chk({req, " R6 vid"}, r, {2'b00, m_vid[bi][12], 1'b1, m_vid[bi][11:0]});
      rd(3'd0, r);
      chk({req, " R10 db split"}, r,
          {1'b0, 3'd4, m_db[bi][7:4], 3'b000, m_full, m_db[bi][3:0]});
      rd(3'd2, r); chk({req, " R9 data0"}, r, m_dat[bi][15:0]);
      rd(3'd3, r); chk({req, " R9 data1"}, r, m_dat[bi][31:16]);
      rd(3'd4, r); chk({req, " R9 data2"}, r, m_dat[bi][47:32]);
      cur_vid = m_vid[bi];
    end
  endtask

  task automatic walk(input string req, input int exp_n);
    logic found;
    int n = 0;
    set_key(13'h1FFF);
    found = 1'b1;
    while (found && n <= DEPTH) begin
      run_cmd(cmd_word(3'd4, 8'h00));
      check_next(req, found);
      if (found) n++;
    end
    chk({req, " entry count"}, 16'(n), 16'(exp_n));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    logic found;
    int cyc;
    for (int i = 0; i < DEPTH; i++) begin
      m_ok[i] = 1'b0; m_vid[i] = '0; m_db[i] = '0; m_dat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, r); chk("R1 cmd after reset", r, 16'h0000);
    rd(3'd1, r); chk("R1 vid after reset", r, 16'h0000);
    set_key(13'h1FFF);
    run_cmd(cmd_word(3'd4, 8'h00));
    check_next("R1 empty table", found);
    chk("R1 empty get-next", 16'(found), 16'h0);

    // R3 VID register layout
    wr(3'd1, 16'hFABC); rd(3'd1, r); chk("R3 vid layout", r, 16'h3ABC);
    wr(3'd1, 16'h1123); rd(3'd1, r); chk("R3 valid bit", r, 16'h1123);

    // R4 loads from the vector table
    for (int k = 0; k < 6; k++) begin
      load(VEC[k][36:24], 1'b1, VEC[k][23:16], VEC[k][15:0],
           VEC[k][15:0] ^ 16'h5A5A, ~VEC[k][15:0]);
    end

    // R6 R8 ascending walk from the start value
    walk("R8 walk", 6);

    // R4 overwrite of a present VID
    load(13'h0040, 1'b1, 8'h3C, 16'h0321, 16'h2002, 16'h1111);
    set_key(13'h003F);
    run_cmd(cmd_word(3'd4, 8'h00));
    check_next("R4 overwrite", found);
    walk("R4 count", 6);

    // R5 purge present and absent
    load(13'h0FFF, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
    walk("R5 purge", 5);
    load(13'h0777, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
    walk("R5 purge absent", 5);

    // R12 fill, overflow, overwrite when full
    load(13'h0500, 1'b1, 8'h11, 16'h1111, 16'h0, 16'h0);
    load(13'h0600, 1'b1, 8'h22, 16'h2222, 16'h0, 16'h0);
    load(13'h0700, 1'b1, 8'h33, 16'h3333, 16'h0, 16'h0);
    rd(3'd0, r); chk("R12 full flag clear at 8", 16'(r[4]), 16'h0);
    load(13'h0800, 1'b1, 8'h44, 16'h1212, 16'h0, 16'h0);
    rd(3'd0, r); chk("R12 full flag set", 16'(r[4]), 16'h1);
    walk("R12 table unchanged", 8);
    load(13'h0600, 1'b1, 8'h9B, 16'h0102, 16'h0, 16'h0);
    set_key(13'h05FF);
    run_cmd(cmd_word(3'd4, 8'h00));
    check_next("R12 overwrite when full", found);
    rd(3'd0, r); chk("R12 full sticky", 16'(r[4]), 16'h1);

    // R13 writes while busy, the last one on the commit edge
    set_key(13'h1FFF);
    wr(3'd0, cmd_word(3'd4, 8'h00));
    wr(3'd2, 16'hAAAA);
    repeat (DEPTH - 1) @(posedge clk);
    wr(3'd1, 16'h0005);
    wait_idle(cyc);
    check_next("R13 busy writes ignored", found);

    // R11 flush
    run_cmd(cmd_word(3'd1, 8'h00));
    m_full = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_ok[i] = 1'b0;
    rd(3'd0, r); chk("R11 full cleared", 16'(r[4]), 16'h0);
    walk("R11 flushed", 0);

    // R9 port-state bits are not kept
    load(13'h0777, 1'b1, 8'hA5, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    set_key(13'h1FFF);
    run_cmd(cmd_word(3'd4, 8'h00));
    rd(3'd2, r); chk("R9 state bits dropped d0", r, 16'h3333);
    rd(3'd4, r); chk("R9 state bits dropped d2", r, 16'h3333);
    rd(3'd0, r); chk("R10 db fields", r, 16'h4A05);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule